// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch and Accumulate Unit

This block runs the operand side of one register-memory ALU instruction of the form "destination register gets destination plus operand". An instruction arrives on a single-cycle `issue` strobe. It carries a 4-bit mode code, three 3-bit register numbers (destination, source/base, index), a 16-bit literal and a 2-bit element-size code. The unit picks the operand in one of ten ways. The operand can be a register, the sign-extended literal, or a word read from data memory at an address built from the base, the index, the literal and the element size. One mode makes two dependent reads, using the first word read as the second address. The unit writes the sum back into its own register file of eight 32-bit registers. The two auto modes also step the base register by the element size. One of them steps the base before the read and the other steps it after the read.

Data memory is word addressed. It answers a read request one cycle later, on `mem_rdata`. The one write port of the register file is brought out on `wr_en`, `wr_idx` and `wr_data`, so every register change can be seen as it happens. `done` pulses once for each instruction that completes. `err` pulses for an illegal mode code. While an instruction is in flight the unit accepts no new `issue`.

Top module: `ea_operand_unit`

## Requirements
- R1: After reset all eight registers read as zero, and `done`, `err`, `mem_rd_en` and `wr_en` are low until the first instruction is accepted.
- R2: Mode code 0 (register) writes Rd + Rs to Rd. The write shows on the write port in the issue cycle, and `done` is high in the next cycle. No memory read is made.
- R3: Mode code 1 (immediate) writes Rd plus the 16-bit literal sign-extended to 32 bits. Timing is the same as in R2.
- R4: The single-read address modes use these addresses: code 2 uses the sign-extended literal plus Rb, code 3 uses Rb, code 4 uses Rb + Ri, and code 5 uses the literal zero-extended to 32 bits.
- R5: A memory mode raises `mem_rd_en` with the address for exactly one cycle, the cycle after issue. The read data is taken in the cycle after that, in which Rd gets Rd + data on the write port. `done` follows one cycle later.
- R6: Mode code 6 (memory indirect) first reads at Rb. It then reads at the returned word, with `mem_rd_en` two cycles after the first request. The sum uses the second word, and `done` comes one cycle after the second data return.
- R7: Mode code 7 (post-increment) reads at the old Rb. In the issue cycle it writes Rb + d to Rb through the write port.
- R8: Mode code 8 (pre-decrement) writes Rb − d to Rb in the issue cycle and reads at Rb − d, with 32-bit wrap-around.
- R9: Mode code 9 (scaled) reads at the sign-extended literal + Rb + Ri·d.
- R10: Element-size codes 0, 1, 2 and 3 select d = 1, 2, 4 and 8.
- R11: In modes 7 and 8, when Rd and Rb are the same register, the base update is dropped. Rd ends as its old value plus the memory word.
- R12: Mode codes 10 to 15 make `err` high in the next cycle. They raise no `done`, no memory read and no register write.
- R13: An `issue` while an instruction is still in flight is ignored. The cycle in which `done` is high already accepts a new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue | input | 1 | Instruction valid for one cycle |
| mode | input | 4 | Addressing-mode code 0 to 9; 10 to 15 are illegal |
| rd_idx | input | 3 | Destination register |
| src_idx | input | 3 | Source register (mode 0) or base register |
| ndx_idx | input | 3 | Index register |
| lit | input | 16 | Displacement, immediate or absolute address |
| esize | input | 2 | Element-size code |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 32 | Word address of the read |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| wr_en | output | 1 | Register file write this cycle |
| wr_idx | output | 3 | Register being written |
| wr_data | output | 32 | Value being written |
| done | output | 1 | Instruction completed (one-cycle pulse) |
| err | output | 1 | Illegal mode code seen (one-cycle pulse) |

## Verification
The bench builds the unit with its default parameters: 32-bit data, eight registers and a 16-bit literal. At these values a literal with bit 15 set exercises sign extension against zero extension. A small base stepped down by eight wraps around 32 bits. A 3-bit register number lets the destination and the base collide often in the seeded random phase. All four element sizes are driven through the post-increment, pre-decrement and scaled address paths. A bench-side memory function returns words spread over the full 32-bit range, so the second read of memory-indirect mode lands on addresses far from the first.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    AM_REG     = 4'd0,
    AM_IMM     = 4'd1,
    AM_DISP    = 4'd2,
    AM_RIND    = 4'd3,
    AM_INDEX   = 4'd4,
    AM_ABS     = 4'd5,
    AM_MIND    = 4'd6,
    AM_POSTINC = 4'd7,
    AM_PREDEC  = 4'd8,
    AM_SCALED  = 4'd9
  } amode_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_REQ1,
    SQ_RET1,
    SQ_REQ2,
    SQ_RET2
  } seq_t;
endpackage

// File: rtl/ea_rst_sync.sv
module ea_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_ns = s2_q;
endmodule

// File: rtl/ea_regfile.sv
module ea_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] addr_a,
  output logic [DW-1:0] data_a,
  input  logic [RW-1:0] addr_b,
  output logic [DW-1:0] data_b,
  input  logic [RW-1:0] addr_c,
  output logic [DW-1:0] data_c
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          hit;
    logic [DW-1:0] q;
    assign hit = we && (waddr == RW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wdata;
    end
    assign regs[g] = q;
  end

  assign data_a = regs[addr_a];
  assign data_b = regs[addr_b];
  assign data_c = regs[addr_c];
endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  amode_t        md,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] index,
  input  logic [LW-1:0] lit,
  input  logic [1:0]    esize,
  output logic [DW-1:0] sext_lit,
  output logic [DW-1:0] ea,
  output logic [DW-1:0] base_new,
  output logic          mem_op,
  output logic          auto_op,
  output logic          bad
);
  logic [DW-1:0] step;
  logic [DW-1:0] scaled_ndx;

  assign step       = DW'(1) << esize;
  assign scaled_ndx = index << esize;
  assign sext_lit   = {{(DW-LW){lit[LW-1]}}, lit};

  always_comb begin
    ea       = base;
    base_new = base;
    mem_op   = 1'b1;
    auto_op  = 1'b0;
    bad      = 1'b0;
    case (md)
      AM_REG, AM_IMM: mem_op = 1'b0;
      AM_DISP:        ea = sext_lit + base;
      AM_RIND:        ea = base;
      AM_INDEX:       ea = base + index;
      AM_ABS:         ea = {{(DW-LW){1'b0}}, lit};
      AM_MIND:        ea = base;
      AM_POSTINC: begin
        ea       = base;
        base_new = base + step;
        auto_op  = 1'b1;
      end
      AM_PREDEC: begin
        base_new = base - step;
        ea       = base - step;
        auto_op  = 1'b1;
      end
      AM_SCALED:      ea = sext_lit + base + scaled_ndx;
      default: begin
        mem_op = 1'b0;
        bad    = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ea_operand_unit.sv
module ea_operand_unit
  import ea_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8,
  parameter int LW   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue,
  input  logic [3:0]              mode,
  input  logic [$clog2(NREG)-1:0] rd_idx,
  input  logic [$clog2(NREG)-1:0] src_idx,
  input  logic [$clog2(NREG)-1:0] ndx_idx,
  input  logic [LW-1:0]           lit,
  input  logic [1:0]              esize,
  output logic                    mem_rd_en,
  output logic [DW-1:0]           mem_addr,
  input  logic [DW-1:0]           mem_rdata,
  output logic                    wr_en,
  output logic [$clog2(NREG)-1:0] wr_idx,
  output logic [DW-1:0]           wr_data,
  output logic                    done,
  output logic                    err
);
  localparam int RW = $clog2(NREG);

  logic rst_ns;
  ea_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  seq_t          state_q, state_d;
  logic [RW-1:0] rd_q, rd_d;
  logic          mind_q, mind_d;
  logic [DW-1:0] addr_q, addr_d;
  logic          ren_q, ren_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          busy;

  logic [DW-1:0] rf_a, rf_b, rf_c;
  logic [RW-1:0] rf_c_sel;
  logic          we;
  logic [RW-1:0] widx;
  logic [DW-1:0] wdat;

  amode_t        md;
  logic [DW-1:0] sext_lit, ea, base_new;
  logic          mem_op, auto_op, bad;

  assign md       = amode_t'(mode);
  assign busy     = (state_q != SQ_IDLE);
  assign rf_c_sel = busy ? rd_q : rd_idx;

  ea_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_ns),
    .we(we), .waddr(widx), .wdata(wdat),
    .addr_a(src_idx), .data_a(rf_a),
    .addr_b(ndx_idx), .data_b(rf_b),
    .addr_c(rf_c_sel), .data_c(rf_c)
  );

  ea_addr_gen #(.DW(DW), .LW(LW)) u_ag (
    .md(md), .base(rf_a), .index(rf_b), .lit(lit), .esize(esize),
    .sext_lit(sext_lit), .ea(ea), .base_new(base_new),
    .mem_op(mem_op), .auto_op(auto_op), .bad(bad)
  );

  // next-state and write-port selection
  always_comb begin
    state_d = state_q;
    rd_d    = rd_q;
    mind_d  = mind_q;
    addr_d  = addr_q;
    ren_d   = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    we      = 1'b0;
    widx    = rd_q;
    wdat    = rf_c + mem_rdata;
    case (state_q)
      SQ_IDLE: begin
        if (issue) begin
          if (bad) begin
            err_d = 1'b1;
          end else if (!mem_op) begin
            we     = 1'b1;
            widx   = rd_idx;
            wdat   = rf_c + ((md == AM_REG) ? rf_a : sext_lit);
            done_d = 1'b1;
          end else begin
            addr_d  = ea;
            ren_d   = 1'b1;
            rd_d    = rd_idx;
            mind_d  = (md == AM_MIND);
            state_d = SQ_REQ1;
            if (auto_op && (src_idx != rd_idx)) begin
              we   = 1'b1;
              widx = src_idx;
              wdat = base_new;
            end
          end
        end
      end
      SQ_REQ1: state_d = SQ_RET1;
      SQ_RET1: begin
        if (mind_q) begin
          addr_d  = mem_rdata;
          ren_d   = 1'b1;
          state_d = SQ_REQ2;
        end else begin
          we      = 1'b1;
          done_d  = 1'b1;
          state_d = SQ_IDLE;
        end
      end
      SQ_REQ2: state_d = SQ_RET2;
      SQ_RET2: begin
        we      = 1'b1;
        done_d  = 1'b1;
        state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  logic ld_ctx;
  assign ld_ctx = (state_q == SQ_IDLE) && issue && mem_op;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= SQ_IDLE;
      rd_q    <= '0;
      mind_q  <= 1'b0;
      addr_q  <= '0;
      ren_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ren_q   <= ren_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (ld_ctx) begin
        rd_q   <= rd_d;
        mind_q <= mind_d;
      end
      if (ren_d) addr_q <= addr_d;
    end
  end

  assign mem_rd_en = ren_q;
  assign mem_addr  = addr_q;
  assign wr_en     = we;
  assign wr_idx    = widx;
  assign wr_data   = wdat;
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/ea_operand_unit_chk.sv
module ea_operand_unit_chk (
  input logic       clk,
  input logic       rst_ns,
  input logic       issue,
  input logic [3:0] mode,
  input logic       busy,
  input logic       mem_rd_en,
  input logic       wr_en,
  input logic       done,
  input logic       err
);
  // R2 / R3: register and immediate modes complete one cycle after issue
  assert_regimm_done_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (issue && !busy && mode <= 4'd1) |=> (done && !mem_rd_en));

  // R5: memory modes request a read in the cycle after issue
  assert_mem_request_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    (issue && !busy && mode >= 4'd2 && mode <= 4'd9) |=> (mem_rd_en && !done));

  // R5: a read request lasts exactly one cycle
  assert_single_read_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_rd_en |=> !mem_rd_en);

  // R5: data return cycle is never the completion cycle
  assert_return_not_done_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_rd_en |=> !done);

  // R12: illegal codes flag an error and touch nothing
  assert_illegal_err_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    (issue && !busy && mode > 4'd9) |=> (err && !done && !mem_rd_en));

  assert_illegal_nowrite_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    (issue && !busy && mode > 4'd9) |-> !wr_en);

  // R12: error and completion never coincide
  assert_err_done_excl_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    !(err && done));

  // R13: an issue while busy cannot raise an error
  assert_busy_ignore_R13: assert property (@(posedge clk) disable iff (!rst_ns)
    (issue && busy && mode > 4'd9) |=> !err);
endmodule

bind ea_operand_unit ea_operand_unit_chk u_chk (
  .clk(clk), .rst_ns(rst_ns), .issue(issue), .mode(mode), .busy(busy),
  .mem_rd_en(mem_rd_en), .wr_en(wr_en), .done(done), .err(err)
);

// File: tb/test_ea_operand_unit.sv
module test_ea_operand_unit;
  localparam int NCYC = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  mode = '0;
  logic [2:0]  rd_idx = '0, src_idx = '0, ndx_idx = '0;
  logic [15:0] lit = '0;
  logic [1:0]  esize = '0;
  logic        mem_rd_en, wr_en, done, err;
  logic [31:0] mem_addr, wr_data;
  logic [31:0] mem_rdata = '0;
  logic [2:0]  wr_idx;

  always #2 clk = ~clk;

  ea_operand_unit i_ea_operand_unit (
    .clk(clk), .rst_n(rst_n), .issue(issue), .mode(mode),
    .rd_idx(rd_idx), .src_idx(src_idx), .ndx_idx(ndx_idx), .lit(lit), .esize(esize),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .done(done), .err(err)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a ^ 32'hC3A5_0F1E) * 32'h0001_0DCD + 32'h1357_9BDF;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= memf(mem_addr);

  // expected per-cycle schedule
  logic        exp_done [NCYC];
  logic        exp_err  [NCYC];
  logic        exp_ren  [NCYC];
  logic [31:0] exp_addr [NCYC];
  logic        exp_we   [NCYC];
  logic [2:0]  exp_widx [NCYC];
  logic [31:0] exp_wdat [NCYC];
  logic [31:0] mreg [8];

  int    k = 0;
  int    free_at = 0;
  int    errors = 0;
  int    checks = 0;
  bit    finished = 0;
  string cur_tag = "R1";

  task automatic model_issue(input int md, input int rd, input int rs, input int ri,
                             input logic [15:0] lt, input int sc);
    logic [31:0] sx, d, base, a, nb, dat;
    int w;
    sx = {{16{lt[15]}}, lt};
    d  = 32'd1 << sc;
    if (md > 9) begin
      exp_err[k+1] = 1'b1;
      free_at = k + 1;
      return;
    end
    if (md <= 1) begin
      dat = mreg[rd] + ((md == 0) ? mreg[rs] : sx);
      exp_we[k] = 1'b1; exp_widx[k] = 3'(rd); exp_wdat[k] = dat;
      mreg[rd] = dat;
      exp_done[k+1] = 1'b1;
      free_at = k + 1;
      return;
    end
    base = mreg[rs];
    nb = base;
    case (md)
      2: a = sx + base;
      3: a = base;
      4: a = base + mreg[ri];
      5: a = {16'h0, lt};
      6: a = base;
      7: begin a = base; nb = base + d; end
      8: begin nb = base - d; a = nb; end
      default: a = sx + base + mreg[ri] * d;
    endcase
    if ((md == 7 || md == 8) && rs != rd) begin
      exp_we[k] = 1'b1; exp_widx[k] = 3'(rs); exp_wdat[k] = nb;
      mreg[rs] = nb;
    end
    exp_ren[k+1] = 1'b1; exp_addr[k+1] = a;
    dat = memf(a);
    if (md == 6) begin
      exp_ren[k+3] = 1'b1; exp_addr[k+3] = dat;
      dat = memf(dat);
      w = k + 4;
    end else begin
      w = k + 2;
    end
    exp_we[w] = 1'b1; exp_widx[w] = 3'(rd); exp_wdat[w] = mreg[rd] + dat;
    mreg[rd] = mreg[rd] + dat;
    exp_done[w+1] = 1'b1;
    free_at = w + 1;
  endtask

  task automatic compare(input int c);
    bit bad = 0;
    checks++;
    if (done !== exp_done[c] || err !== exp_err[c] || mem_rd_en !== exp_ren[c] ||
        wr_en !== exp_we[c]) bad = 1;
    if (exp_ren[c] && mem_addr !== exp_addr[c]) bad = 1;
    if (exp_we[c] && (wr_idx !== exp_widx[c] || wr_data !== exp_wdat[c])) bad = 1;
    if (bad) begin
      errors++;
      $display("FAIL %s cycle %0d (actual/expected): done=%b/%b err=%b/%b ren=%b/%b addr=%h/%h we=%b/%b idx=%0d/%0d data=%h/%h",
               cur_tag, c, done, exp_done[c], err, exp_err[c], mem_rd_en, exp_ren[c],
               mem_addr, exp_addr[c], wr_en, exp_we[c], wr_idx, exp_widx[c], wr_data, exp_wdat[c]);
    end
  endtask

  task automatic step(input bit iss, input int md, input int rd, input int rs,
                      input int ri, input logic [15:0] lt, input int sc);
    @(posedge clk);
    k++;
    #1;
    issue = iss; mode = 4'(md); rd_idx = 3'(rd); src_idx = 3'(rs);
    ndx_idx = 3'(ri); lit = lt; esize = 2'(sc);
    if (iss && k >= free_at) model_issue(md, rd, rs, ri, lt, sc);
    @(negedge clk);
    compare(k);
  endtask

  task automatic settle();
    while (k + 1 < free_at) step(0, 0, 0, 0, 0, 16'h0, 0);
  endtask

  task automatic run(input int md, input int rd, input int rs, input int ri,
                     input logic [15:0] lt, input int sc);
    step(1, md, rd, rs, ri, lt, sc);
    settle();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < NCYC; i++) begin
      exp_done[i] = 0; exp_err[i] = 0; exp_ren[i] = 0; exp_addr[i] = '0;
      exp_we[i] = 0; exp_widx[i] = '0; exp_wdat[i] = '0;
    end
    for (int i = 0; i < 8; i++) mreg[i] = '0;
  end

  initial begin
    int seed;
    // R1: outputs quiet through reset and synchroniser release
    cur_tag = "R1";
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 16'h0, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 16'h0, 0);
    run(0, 1, 2, 0, 16'h0, 0);              // R1: zero + zero

    cur_tag = "R3";
    run(1, 1, 0, 0, 16'h8000, 0);           // sign-extended negative
    run(1, 2, 0, 0, 16'h0100, 0);
    run(1, 3, 0, 0, 16'h0003, 0);
    run(1, 4, 0, 0, 16'h0040, 0);
    run(1, 5, 0, 0, 16'h0007, 0);
    run(1, 6, 0, 0, 16'h0200, 0);
    run(1, 7, 0, 0, 16'h0004, 0);

    cur_tag = "R2";
    run(0, 1, 2, 0, 16'h0, 0);
    step(1, 0, 3, 3, 0, 16'h0, 0);          // back-to-back register ops
    run(0, 3, 1, 0, 16'h0, 0);

    cur_tag = "R4";
    run(2, 5, 2, 0, 16'hFFF0, 0);
    run(2, 5, 2, 0, 16'h0021, 0);
    run(3, 5, 6, 0, 16'h0, 0);
    run(4, 3, 2, 4, 16'h0, 0);
    run(5, 4, 0, 0, 16'hABCD, 0);           // zero-extended absolute

    cur_tag = "R6";
    run(6, 1, 2, 0, 16'h0, 0);
    run(6, 2, 7, 0, 16'h0, 0);

    cur_tag = "R7";
    run(7, 5, 6, 0, 16'h0, 2);
    cur_tag = "R10";
    for (int s = 0; s < 4; s++) run(7, 5, 6, 0, 16'h0, s);
    for (int s = 0; s < 4; s++) run(9, 3, 2, 4, 16'h0010, s);

    cur_tag = "R8";
    run(1, 7, 7, 0, 16'h0, 0);
    run(8, 5, 7, 0, 16'h0, 3);              // base 4 - 8 wraps
    run(8, 5, 4, 0, 16'h0, 2);

    cur_tag = "R9";
    run(9, 3, 2, 3, 16'h0010, 3);
    run(9, 3, 6, 5, 16'hFF00, 1);

    cur_tag = "R11";
    run(7, 6, 6, 0, 16'h0, 2);
    run(8, 4, 4, 0, 16'h0, 3);

    cur_tag = "R12";
    for (int m = 10; m < 16; m++) run(m, 1, 2, 3, 16'h1234, 1);

    cur_tag = "R13";
    step(1, 6, 1, 2, 0, 16'h0, 0);
    step(1, 0, 1, 2, 0, 16'h0, 0);          // ignored while busy
    step(1, 12, 0, 0, 0, 16'h0, 0);         // ignored while busy
    step(1, 1, 3, 0, 0, 16'h0055, 0);       // ignored while busy
    settle();
    run(1, 3, 0, 0, 16'h0001, 0);

    cur_tag = "R5";
    seed = 32'h2545F491;
    for (int n = 0; n < 300; n++) begin
      int md, rd, rs, ri, sc;
      logic [15:0] lt;
      seed = seed * 1103515245 + 12345; md = (seed >>> 16) & 15;
      seed = seed * 1103515245 + 12345; rd = (seed >>> 16) & 7;
      seed = seed * 1103515245 + 12345; rs = (seed >>> 16) & 7;
      seed = seed * 1103515245 + 12345; ri = (seed >>> 16) & 7;
      seed = seed * 1103515245 + 12345; sc = (seed >>> 16) & 3;
      seed = seed * 1103515245 + 12345; lt = 16'(seed >>> 12);
      step(1, md, rd, rs, ri, lt, sc);
      if ((seed & 32'h300) == 0) step(1, 0, rs, rd, 0, 16'h0, 0);
      settle();
    end
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 16'h0, 0);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog %s: run did not end (actual cycle %0d / expected end before 20000)", cur_tag, k);
    summary();
  end
endmodule